// File: doc/BRIEF.md
# Start-Gated T-State Timing Generator

This block produces the one-hot timing states that sequence a hardwired control unit. A single-cycle start request sets an internal run latch; while that latch is set, a small binary step counter advances once per clock, beginning at zero. The count is decoded into a bank of one-hot T-state lines. Each line marks one step of an instruction cycle in the control logic downstream.

A clear request ends the instruction cycle. It drops the run latch and returns the counter to zero in the same edge, so all T-state lines go low. If the cycle runs past the last state without a clear, the counter wraps to the first state and the sequence repeats. A valid output shows when the T-state lines are meaningful. Combining T-states with opcodes into control signals is left to the surrounding logic.

Top module: `tstate_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release with no start, `valid_o` is 0 and every bit of `tstate_o` is 0.
- R2: A start request (`start_i` high at a clock edge, `clear_i` low, block idle) gives `valid_o` = 1 and `tstate_o` = 1 (bit 0, the first T-state) after that edge.
- R3: While `valid_o` is 1 and `clear_i` is low, each clock edge moves the single high bit of `tstate_o` from bit k to bit k+1.
- R4: While `valid_o` is 1, exactly one bit of `tstate_o` is high; bit k high means the counter holds the value k.
- R5: From the last T-state (bit 2^CNT_W-1, bit 7 by default), the next edge without clear returns to bit 0, and `valid_o` stays 1.
- R6: `clear_i` high at a clock edge gives `valid_o` = 0 and `tstate_o` = 0 after that edge; a later start begins again at bit 0.
- R7: When `start_i` and `clear_i` are both high at the same edge, clear wins: the block is idle after that edge.
- R8: `start_i` high while the block is already running has no effect: the sequence keeps advancing as in R3 and does not restart.
- R9: While `valid_o` is 0, `tstate_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction cycle (sets run latch) |
| clear_i | input | 1 | End the instruction cycle (synchronous, priority over start) |
| tstate_o | output | 2^CNT_W (8) | One-hot decoded T-state |
| valid_o | output | 1 | High while the run latch is set |

## Verification
On every cycle the assertions check the one-hot property while running, all-zero outputs while idle, the rotate-by-one step including the wrap, the entry to the first T-state after a start from idle, and the effect of clear. The scenarios in the bench show the longer sequences that span many states: the full walk through a cycle and back, restart at the first state after a clear, clear winning over a simultaneous start, a repeated start that leaves the count untouched, and the reset state.

// File: rtl/tstate_pkg.sv
package tstate_pkg;
  localparam int unsigned CNT_W_DEF = 3;

  function automatic int unsigned n_states(input int unsigned cnt_w);
    return 32'd1 << cnt_w;
  endfunction
endpackage

// File: rtl/tstate_run_latch.sv
module tstate_run_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic run_o
);
  logic run_q;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (clr_i)   run_q <= 1'b0;
    else if (set_i)   run_q <= 1'b1;
  end

  assign run_o = run_q;
endmodule

// File: rtl/tstate_step_cnt.sv
module tstate_step_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // natural width overflow gives the wrap to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tstate_decode.sv
module tstate_decode #(
  parameter int unsigned CNT_W = 3,
  localparam int unsigned NST  = 1 << CNT_W
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [NST-1:0]   hot_o
);
  for (genvar i = 0; i < NST; i++) begin : g_line
    assign hot_o[i] = en_i && (cnt_i == CNT_W'(i));
  end
endmodule

// File: rtl/tstate_gen.sv
module tstate_gen
  import tstate_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  localparam int unsigned NST  = 1 << CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           clear_i,
  output logic [NST-1:0] tstate_o,
  output logic           valid_o
);
  logic             run;
  logic [CNT_W-1:0] cnt;

  tstate_run_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (start_i),
    .clr_i  (clear_i),
    .run_o  (run)
  );

  // counter steps only once the latch is already set: first run cycle shows 0
  tstate_step_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .clr_i  (clear_i),
    .cnt_o  (cnt)
  );

  tstate_decode #(.CNT_W(CNT_W)) u_dec (
    .en_i  (run),
    .cnt_i (cnt),
    .hot_o (tstate_o)
  );

  assign valid_o = run;
endmodule

// File: rtl/tstate_gen_chk.sv
module tstate_gen_chk #(
  parameter int unsigned CNT_W = 3,
  localparam int unsigned NST  = 1 << CNT_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           clear_i,
  input logic [NST-1:0] tstate_o,
  input logic           valid_o
);
  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(tstate_o) == 1);

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> tstate_o == '0);

  // R5 wrap is covered by the rotate
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clear_i) |=> (valid_o && tstate_o == {$past(tstate_o[NST-2:0]), $past(tstate_o[NST-1])}));

  a_r2_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && start_i && !clear_i) |=> (valid_o && tstate_o == NST'(1)));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!valid_o && tstate_o == '0));

  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind tstate_gen tstate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .clear_i  (clear_i),
  .tstate_o (tstate_o),
  .valid_o  (valid_o)
);

// File: tb/tstate_gen_bench.sv
`timescale 1ns/1ps
module tstate_gen_bench;
  localparam int unsigned CNT_W = 3;
  localparam int unsigned NST   = 1 << CNT_W;

  typedef struct {
    logic           valid;
    logic [NST-1:0] hot;
    string          tag;
  } exp_t;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic           clear_i = 1'b0;
  logic [NST-1:0] tstate_o;
  logic           valid_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  exp_t sb_q[$];

  // reference model
  bit                m_run = 1'b0;
  logic [CNT_W-1:0]  m_cnt = '0;

  always #10 clk_i = ~clk_i;

  tstate_gen #(.CNT_W(CNT_W)) u_tstate_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .clear_i  (clear_i),
    .tstate_o (tstate_o),
    .valid_o  (valid_o)
  );

  task automatic check(input string tag, input logic [NST:0] act, input logic [NST:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid/tstate=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: drive at negedge, push expected result after the next posedge
  task automatic step(input bit st, input bit cl, input string tag);
    exp_t e;
    @(negedge clk_i);
    start_i = st;
    clear_i = cl;
    if (cl) begin
      m_run = 1'b0;
      m_cnt = '0;
    end else begin
      if (m_run) m_cnt = m_cnt + 1'b1;
      if (st) m_run = 1'b1;
    end
    e.valid = m_run;
    e.hot   = m_run ? (NST'(1) << m_cnt) : '0;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  // monitor: sample mid high phase
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {valid_o, tstate_o}, {e.valid, e.hot});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 5000 && !done) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #35;
    check("R1 in reset", {valid_o, tstate_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R1 idle after reset");
    step(1'b1, 1'b0, "R2 start enters T0");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R3 advance one per clock");
    step(1'b0, 1'b0, "R5 wrap to T0");
    step(1'b0, 1'b0, "R4 onehot after wrap");
    step(1'b0, 1'b1, "R6 clear to idle");
    step(1'b0, 1'b0, "R9 idle zero");
    step(1'b1, 1'b0, "R6 restart at T0");
    step(1'b0, 1'b0, "R3 T1 after restart");
    step(1'b1, 1'b0, "R8 start while running");
    step(1'b1, 1'b0, "R8 start while running again");
    step(1'b0, 1'b0, "R8 still advancing");
    step(1'b1, 1'b1, "R7 clear beats start");
    step(1'b0, 1'b0, "R7 idle after tie");
    step(1'b1, 1'b1, "R7 tie from idle");
    step(1'b0, 1'b0, "R9 idle stays zero");
    step(1'b1, 1'b0, "R2 second start");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R4 single hot bit");
    step(1'b0, 1'b0, "R3 drain");
    repeat (3) @(posedge clk_i);
    #6;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule